// File: doc/BRIEF.md
# Biphase Line Transmit Framer

This block assembles one line frame per frame strobe from a pair of B-channel octets, a pair of D-channel bits and a housekeeping bit. It then sends the frame as a biphase code, two half-cell levels per bit. The clock runs at twice the baud rate. Each clock edge emits one half-cell, so every bit takes two cycles. All data and mode inputs are captured on the strobe edge. The caller may change them freely while the frame is going out.

Three controls set the frame layout. The rate select picks a short frame or a long frame. The mode select picks a framed layout or an unframed modem stream. The D-in-B option moves the D-channel bits into the B1 timeslot. In framed mode a leading sync bit alternates from frame to frame, so a receiver can find the frame boundary.

A line disable pin and a diagnostic disable bit can each force the output to its idle, mid-bias state. Framing keeps running in the background while the output is disabled. When a frame ends and no new strobe has arrived, the output also falls back to idle.

Top module: `line_tx_framer`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `line_idle` is 1 and `line_sym` is 0.
- R2: A bit of value 0 is sent as the half-cell pair (1, 0) and a bit of value 1 as (0, 1). The first half is the complement of the bit, and the level always changes at mid-cell.
- R3: Framed mode with `rate_hi`=0 sends 10 bits in this order: sync, `d_bits[0]`, then `b1_oct` MSB first.
- R4: Framed mode with `rate_hi`=1 sends 20 bits in this order: sync, `hk_bit`, `d_bits[1]`, `d_bits[0]`, then `b1_oct` MSB first, then `b2_oct` MSB first.
- R5: The sync bit of the first framed frame after reset is 1. It inverts on every later framed frame. Modem-mode frames leave the sync sequence unchanged.
- R6: With `d_in_b`=1 in framed mode, the D bit positions carry 1. The B1 slot then carries the D bits first, followed by the low-order bits of `b1_oct` that still fit: {`d_bits[0]`, `b1_oct[6:0]`} at the low rate, and {`d_bits[1]`, `d_bits[0]`, `b1_oct[5:0]`} at the high rate.
- R7: With `modem_sel`=1, a frame is `b1_oct` alone (8 bits) at the low rate, or `b1_oct` then `b2_oct` (16 bits) at the high rate. No sync, housekeeping or D bits are sent.
- R8: The frame content is fixed by the input values at the strobe edge. Input changes after that edge do not alter the frame in flight.
- R9: The first half-cell of a frame appears one cycle after the strobe edge. After the last half-cell the output goes to idle (`line_idle`=1, `line_sym`=0) until the next strobe.
- R10: When `line_dis_pin` or `diag_dis` is 1 at an edge, the next cycle shows `line_idle`=1 and `line_sym`=0. Frame timing and the sync sequence keep advancing while the output is disabled.
- R11: A strobe always restarts framing at the new frame's first bit. A strobe on the frame's final cycle gives a gap-free stream, and a strobe in mid-frame abandons the rest of the old frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cell clock, twice the baud rate |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | Frame strobe; captures inputs and starts a frame |
| rate_hi | input | 1 | 0 selects the short frame, 1 the long frame |
| modem_sel | input | 1 | 1 selects the unframed modem stream |
| d_in_b | input | 1 | 1 carries the D bits inside the B1 slot |
| line_dis_pin | input | 1 | External transmit disable |
| diag_dis | input | 1 | Diagnostic transmit disable |
| b1_oct | input | 8 | B1 channel octet |
| b2_oct | input | 8 | B2 channel octet |
| d_bits | input | 2 | D-channel bits; bit 1 is sent first |
| hk_bit | input | 1 | Housekeeping bit |
| line_sym | output | 1 | Half-cell line level |
| line_idle | output | 1 | 1 while the line is held at bias |

## Verification
Each fault in the internal state shows at the ports within one or two half-cells:
- A miscounted half-cell counter pulls the wrong bit out of the frame word, or ends the frame at the wrong point. The bench sees this as a wrong level or as a premature or late idle.
- A captured field that is not held steady alters a bit that the bench predicts from the values present at the strobe.
- A sync flag that misses a toggle turns up on the very first half-cell of the next framed frame.
- A disable that is ignored leaves a live level where idle is expected, one cycle after the control rises.

// File: rtl/ltx_pkg.sv
package ltx_pkg;
  localparam int OCT_W    = 8;
  localparam int MAX_BITS = 4 + 2 * OCT_W;
  localparam int LEN_W    = $clog2(MAX_BITS + 1);
  localparam int HC_W     = $clog2(2 * MAX_BITS);

  typedef struct packed {
    logic [OCT_W-1:0] b1;
    logic [OCT_W-1:0] b2;
    logic [1:0]       d;
    logic             hk;
    logic             rate_hi;
    logic             modem;
    logic             dinb;
    logic             sync;
  } ltx_fields_t;
endpackage

// File: rtl/ltx_frame_builder.sv
module ltx_frame_builder
  import ltx_pkg::*;
(
  input  ltx_fields_t         f,
  output logic [MAX_BITS-1:0] word,
  output logic [LEN_W-1:0]    len
);
  localparam int PAD_LO  = MAX_BITS - 2 - OCT_W;
  localparam int PAD_MOD = MAX_BITS - 2 * OCT_W;

  logic [OCT_W-1:0] slot_lo, slot_hi;
  logic             dpos_lo;
  logic [1:0]       dpos_hi;

  always_comb begin
    slot_lo = f.dinb ? {f.d[0], f.b1[OCT_W-2:0]} : f.b1;
    slot_hi = f.dinb ? {f.d, f.b1[OCT_W-3:0]} : f.b1;
    dpos_lo = f.dinb ? 1'b1 : f.d[0];
    dpos_hi = f.dinb ? 2'b11 : f.d;
    if (f.modem) begin
      word = {f.b1, f.b2, {PAD_MOD{1'b0}}};
      len  = f.rate_hi ? LEN_W'(2 * OCT_W) : LEN_W'(OCT_W);
    end else if (!f.rate_hi) begin
      word = {f.sync, dpos_lo, slot_lo, {PAD_LO{1'b0}}};
      len  = LEN_W'(2 + OCT_W);
    end else begin
      word = {f.sync, f.hk, dpos_hi, slot_hi, f.b2};
      len  = LEN_W'(MAX_BITS);
    end
  end
endmodule

// File: rtl/ltx_serializer.sv
module ltx_serializer
  import ltx_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                stb,
  input  logic [MAX_BITS-1:0] word,
  input  logic [LEN_W-1:0]    len,
  output logic                active_o,
  output logic                bit_o,
  output logic                half_o
);
  localparam int IDX_W = HC_W - 1;

  logic [HC_W-1:0]     hc_q;
  logic                active_q;
  logic [HC_W-1:0]     hc_end;
  logic [IDX_W-1:0]    idx;
  logic [MAX_BITS-1:0] sh;

  assign hc_end = HC_W'({len, 1'b0}) - HC_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      hc_q     <= '0;
      active_q <= 1'b0;
    end else if (stb) begin
      hc_q     <= '0;
      active_q <= 1'b1;
    end else if (active_q) begin
      if (hc_q == hc_end) active_q <= 1'b0;
      else                hc_q     <= hc_q + HC_W'(1);
    end
  end

  always_comb begin
    idx    = hc_q[HC_W-1:1];
    sh     = word << idx;
    bit_o  = sh[MAX_BITS-1];
    half_o = hc_q[0];
  end

  assign active_o = active_q;

  // R9
  hc_bound_chk: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (hc_q <= hc_end));

  // R11
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    stb |=> (active_q && hc_q == '0));
endmodule

// File: rtl/ltx_biphase_enc.sv
module ltx_biphase_enc (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic bit_i,
  input  logic half_i,
  input  logic dis,
  output logic line_sym,
  output logic line_idle
);
  logic ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_sym  <= 1'b0;
      line_idle <= 1'b1;
      ph_q      <= 1'b0;
    end else begin
      ph_q <= half_i;
      if (!active || dis) begin
        line_sym  <= 1'b0;
        line_idle <= 1'b1;
      end else begin
        line_sym  <= half_i ? bit_i : ~bit_i;
        line_idle <= 1'b0;
      end
    end
  end

  // R10
  disable_idle_chk: assert property (@(posedge clk) disable iff (rst)
    dis |=> (line_idle && !line_sym));

  // R2
  mid_cell_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (ph_q && !line_idle && $past(!line_idle)) |-> (line_sym != $past(line_sym)));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    line_idle |-> !line_sym);
endmodule

// File: rtl/line_tx_framer.sv
module line_tx_framer
  import ltx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_stb,
  input  logic             rate_hi,
  input  logic             modem_sel,
  input  logic             d_in_b,
  input  logic             line_dis_pin,
  input  logic             diag_dis,
  input  logic [OCT_W-1:0] b1_oct,
  input  logic [OCT_W-1:0] b2_oct,
  input  logic [1:0]       d_bits,
  input  logic             hk_bit,
  output logic             line_sym,
  output logic             line_idle
);
  ltx_fields_t         fields_q;
  logic                sync_q;
  logic [MAX_BITS-1:0] word;
  logic [LEN_W-1:0]    len;
  logic                active, cur_bit, cur_half;

  always_ff @(posedge clk) begin
    if (rst) begin
      fields_q <= '0;
      sync_q   <= 1'b1;
    end else if (frame_stb) begin
      fields_q.b1      <= b1_oct;
      fields_q.b2      <= b2_oct;
      fields_q.d       <= d_bits;
      fields_q.hk      <= hk_bit;
      fields_q.rate_hi <= rate_hi;
      fields_q.modem   <= modem_sel;
      fields_q.dinb    <= d_in_b;
      fields_q.sync    <= sync_q;
      if (!modem_sel) sync_q <= ~sync_q;
    end
  end

  // R5
  sync_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && !modem_sel) |=> (sync_q != $past(sync_q)));

  // R5
  sync_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && modem_sel) |=> $stable(sync_q));

  ltx_frame_builder u_build (
    .f    (fields_q),
    .word (word),
    .len  (len)
  );

  ltx_serializer u_ser (
    .clk      (clk),
    .rst      (rst),
    .stb      (frame_stb),
    .word     (word),
    .len      (len),
    .active_o (active),
    .bit_o    (cur_bit),
    .half_o   (cur_half)
  );

  ltx_biphase_enc u_enc (
    .clk       (clk),
    .rst       (rst),
    .active    (active),
    .bit_i     (cur_bit),
    .half_i    (cur_half),
    .dis       (line_dis_pin | diag_dis),
    .line_sym  (line_sym),
    .line_idle (line_idle)
  );
endmodule

// File: tb/test_line_tx_framer.sv
module test_line_tx_framer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_stb = 1'b0, rate_hi = 1'b0, modem_sel = 1'b0, d_in_b = 1'b0;
  logic       line_dis_pin = 1'b0, diag_dis = 1'b0, hk_bit = 1'b0;
  logic [7:0] b1_oct = '0, b2_oct = '0;
  logic [1:0] d_bits = '0;
  logic       line_sym, line_idle;

  int vectors = 0, miscompares = 0;
  bit done = 0;
  bit bsync = 1'b1;
  bit pending = 0;
  logic pend_sym, pend_idle;

  always #4 clk = ~clk;

  line_tx_framer i_line_tx_framer (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .rate_hi(rate_hi),
    .modem_sel(modem_sel), .d_in_b(d_in_b), .line_dis_pin(line_dis_pin),
    .diag_dis(diag_dis), .b1_oct(b1_oct), .b2_oct(b2_oct), .d_bits(d_bits),
    .hk_bit(hk_bit), .line_sym(line_sym), .line_idle(line_idle)
  );

  task automatic check(input logic es, input logic ei, input string tag);
    vectors++;
    if (line_sym !== es || line_idle !== ei) begin
      miscompares++;
      $display("FAIL %s: sym/idle got %b/%b expected %b/%b", tag, line_sym, line_idle, es, ei);
    end
  endtask

  function automatic logic [19:0] exp_word(input logic [7:0] b1, b2, input logic [1:0] d,
      input logic hk, rt, md, db, s, output int len);
    logic [19:0] w;
    w = '0;
    if (md) begin                      // R7
      w[19:12] = b1;
      if (rt) w[11:4] = b2;
      len = rt ? 16 : 8;
    end else if (!rt) begin            // R3, R6
      w[19] = s;
      w[18] = db ? 1'b1 : d[0];
      w[17:10] = db ? {d[0], b1[6:0]} : b1;
      len = 10;
    end else begin                     // R4, R6
      w[19] = s;
      w[18] = hk;
      w[17:16] = db ? 2'b11 : d;
      w[15:8] = db ? {d, b1[5:0]} : b1;
      w[7:0] = b2;
      len = 20;
    end
    return w;
  endfunction

  task automatic run_frame(input logic [7:0] b1, b2, input logic [1:0] d,
      input logic hk, rt, md, db, pin, diag, input bit chain, input int abort_at,
      input string tag);
    logic [19:0] w;
    int len, nchk;
    logic dis, bt;
    w = exp_word(b1, b2, d, hk, rt, md, db, bsync, len);
    if (!md) bsync = ~bsync;           // R5
    dis = pin | diag;
    b1_oct = b1; b2_oct = b2; d_bits = d; hk_bit = hk;
    rate_hi = rt; modem_sel = md; d_in_b = db;
    line_dis_pin = pin; diag_dis = diag; frame_stb = 1'b1;
    @(posedge clk);
    @(negedge clk);
    if (pending) check(pend_sym, pend_idle, {tag, " R11 chained tail"});
    pending = 0;
    frame_stb = 1'b0;
    // R8: scramble inputs while the frame is in flight
    b1_oct = 8'($urandom); b2_oct = 8'($urandom); d_bits = 2'($urandom);
    hk_bit = 1'($urandom); rate_hi = 1'($urandom); modem_sel = 1'($urandom);
    d_in_b = 1'($urandom);
    nchk = (abort_at > 0) ? abort_at : (chain ? 2 * len - 1 : 2 * len);
    for (int k = 0; k < nchk; k++) begin
      @(posedge clk);
      @(negedge clk);
      bt = w[19 - k / 2];
      check(dis ? 1'b0 : ((k % 2 == 1) ? bt : ~bt), dis, {tag, " R2 R8 R10 half"});
    end
    if (abort_at == 0) begin
      if (chain) begin
        bt = w[19 - (len - 1)];
        pending = 1; pend_sym = dis ? 1'b0 : bt; pend_idle = dis;
      end else begin
        @(posedge clk);
        @(negedge clk);
        check(1'b0, 1'b1, {tag, " R9 idle after frame"});
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4660));
    repeat (3) @(negedge clk);
    check(1'b0, 1'b1, "R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    check(1'b0, 1'b1, "R1 after reset");

    run_frame(8'hA5, 8'h00, 2'b01, 0, 0, 0, 0, 0, 0, 0, 0, "R3 R5 low framed");
    run_frame(8'h3C, 8'hC3, 2'b10, 1, 1, 0, 0, 0, 0, 0, 0, "R4 R5 high framed");
    run_frame(8'h00, 8'h00, 2'b00, 0, 1, 0, 0, 0, 0, 0, 0, "R4 all zero");
    run_frame(8'hFF, 8'hFF, 2'b11, 1, 1, 0, 0, 0, 0, 0, 0, "R4 all one");
    run_frame(8'h96, 8'h00, 2'b00, 0, 0, 0, 1, 0, 0, 0, 0, "R6 low dinb");
    run_frame(8'h69, 8'h81, 2'b10, 0, 1, 0, 1, 0, 0, 0, 0, "R6 high dinb");
    run_frame(8'hB7, 8'h12, 2'b11, 1, 0, 1, 0, 0, 0, 0, 0, "R7 R5 low modem");
    run_frame(8'h4E, 8'hD1, 2'b11, 1, 1, 1, 0, 0, 0, 0, 0, "R7 high modem");
    run_frame(8'h5A, 8'h00, 2'b01, 0, 0, 0, 0, 0, 0, 0, 0, "R5 sync after modem");
    run_frame(8'hF0, 8'h0F, 2'b01, 1, 1, 0, 0, 1, 0, 0, 0, "R10 pin disable");
    run_frame(8'h0F, 8'hF0, 2'b10, 0, 1, 0, 0, 0, 1, 0, 0, "R10 diag disable");
    run_frame(8'h33, 8'h00, 2'b00, 0, 0, 0, 0, 0, 0, 0, 0, "R10 sync advanced");
    run_frame(8'hC6, 8'h39, 2'b01, 1, 1, 0, 0, 0, 0, 1, 0, "R11 chain a");
    run_frame(8'h1D, 8'hE2, 2'b10, 0, 0, 0, 1, 0, 0, 1, 0, "R11 chain b");
    run_frame(8'h77, 8'h88, 2'b00, 0, 1, 1, 0, 0, 0, 0, 0, "R11 chain c");
    run_frame(8'hAA, 8'h55, 2'b11, 1, 1, 0, 0, 0, 0, 0, 5, "R11 abort");
    run_frame(8'h55, 8'hAA, 2'b00, 0, 1, 0, 0, 0, 0, 0, 0, "R11 after restart");

    for (int n = 0; n < 60; n++) begin
      run_frame(8'($urandom), 8'($urandom), 2'($urandom), 1'($urandom),
                1'($urandom), ($urandom % 4) == 0, 1'($urandom),
                ($urandom % 8) == 0, ($urandom % 8) == 0, 0, 0, "R3 R4 R6 R7 random");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule